// File: doc/BRIEF.md
# Low-Power Mode and Brownout Gating Controller

This block holds the processor's reduced-power state and derives every enable that depends on it. Software selects a state by writing a two-bit mode field while the processor runs. From then on the controller decides three things. It sets which clocks stay alive: the processor clock gate, the main oscillator and the internal RC oscillator. It sets which supervisory circuits stay powered: the brownout detectors and the voltage comparators. It sets which wake events return the chip to the run state.

The block also takes three digital brownout comparator levels: one for reset, one for interrupt and one for flash protection. Each level is synchronized. Each is then gated by its own rule for the current mode, which yields a brownout reset request, a sticky brownout interrupt flag and a flash write/erase inhibit. The trip-level selection fields for the reset and interrupt detectors are only carried through to the analog side.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset, mode_o is 00 (run), cpu_clk_en_o, osc_en_o, bod_en_o and cmp_en_o are 1, and bo_irq_flag_o is 0.
- R2: The mode encodings are 00 run, 01 Idle, 10 Power-down and 11 Total Power-down. A mode_wr_i pulse in run loads mode_wdata_i into mode_o at the next clock edge. A write in any other mode is ignored.
- R3: In Idle, cpu_clk_en_o is 0 and osc_en_o is 1. wake_irq_i or wake_rst_i returns mode_o to 00 at the next edge.
- R4: In Power-down and Total Power-down, cpu_clk_en_o and osc_en_o are 0. Only pd_wake_irq_i or wake_rst_i returns mode_o to 00. wake_irq_i alone has no effect.
- R5: bo_rst_req_o equals the synchronized reset-threshold level in every mode except Total Power-down, where it is 0. While it is asserted, Idle and Power-down return to run at the next edge.
- R6: bod_en_o and cmp_en_o are 0 in Total Power-down and 1 in every other mode.
- R7: bo_flash_inh_o equals the synchronized flash-threshold level in run and Idle, and is 0 in both power-down modes.
- R8: bo_irq_flag_o sets on the edge after the synchronized interrupt-threshold level is 1 while bo_irq_en_i is 1 and the mode is not Total Power-down. It then stays set until a bo_irq_clr_i pulse clears it. A set condition in the same cycle as the clear wins.
- R9: rc_osc_en_o is 1 in run and Idle. In both power-down modes it is 1 only when rc_sys_clk_i and rtc_en_i are both 1.
- R10: Each brownout level passes through SYNC_STAGES (default 2) flops. A level change applied before edge k is seen on the outputs after edge k+1 and not after edge k.
- R11: bo_rst_trip_o and bo_irq_trip_o always equal bo_rst_trip_i and bo_irq_trip_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Mode field write strobe |
| mode_wdata_i | input | 2 | Requested mode encoding |
| wake_irq_i | input | 1 | Any enabled interrupt pending |
| pd_wake_irq_i | input | 1 | Pending interrupt from a source able to end power-down |
| wake_rst_i | input | 1 | Reset event from another source |
| bo_irq_en_i | input | 1 | Software enable of the brownout interrupt |
| bo_irq_clr_i | input | 1 | Write-1 clear of the brownout interrupt flag |
| rc_sys_clk_i | input | 1 | RC oscillator is the selected system clock |
| rtc_en_i | input | 1 | Real-time clock enabled |
| bo_lvl_rst_i | input | 1 | Supply below reset threshold (asynchronous) |
| bo_lvl_irq_i | input | 1 | Supply below interrupt threshold (asynchronous) |
| bo_lvl_flash_i | input | 1 | Supply below flash threshold (asynchronous) |
| bo_rst_trip_i | input | TRIP_W | Reset-threshold trip selection |
| bo_irq_trip_i | input | TRIP_W | Interrupt-threshold trip selection |
| mode_o | output | 2 | Current mode |
| cpu_clk_en_o | output | 1 | Processor clock gate enable |
| osc_en_o | output | 1 | Main oscillator run enable |
| rc_osc_en_o | output | 1 | Internal RC oscillator run enable |
| bod_en_o | output | 1 | Brownout detector power enable |
| cmp_en_o | output | 1 | Comparator power enable |
| bo_rst_req_o | output | 1 | Brownout reset request |
| bo_irq_flag_o | output | 1 | Sticky brownout interrupt flag |
| bo_flash_inh_o | output | 1 | Flash program/erase inhibit |
| bo_rst_trip_o | output | TRIP_W | Reset trip selection to the analog side |
| bo_irq_trip_o | output | TRIP_W | Interrupt trip selection to the analog side |

## Verification
A corrupted mode register shows at the ports on the same cycle. The clock and power enables form a fixed pattern for each mode, so a wrong state gives a pattern that mode_o contradicts, or a stuck processor clock that no wake event clears. A synchronizer with the wrong depth moves brownout responses by whole cycles, and the latency check catches this. A mis-gated interrupt flag gives a wrong sticky value that persists until the next clear, so it stays visible for the whole of a low-power interval.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10,
    MODE_TPD  = 2'b11
  } mode_e;

  localparam int unsigned LVL_RST   = 0;
  localparam int unsigned LVL_IRQ   = 1;
  localparam int unsigned LVL_FLASH = 2;
  localparam int unsigned LVL_N     = 3;
endpackage

// File: rtl/pwr_lvl_sync.sv
module pwr_lvl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       wake_irq_i,
  input  logic       pd_wake_irq_i,
  input  logic       wake_rst_i,
  output mode_e      mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (wr_i) mode_d = mode_e'(wdata_i);
      MODE_IDLE: if (wake_irq_i || wake_rst_i) mode_d = MODE_RUN;
      default:   if (pd_wake_irq_i || wake_rst_i) mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R2
  leave_only_to_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_RUN) |=> (mode_q == $past(mode_q) || mode_q == MODE_RUN));

  // R4
  pd_ignores_plain_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_PD || mode_q == MODE_TPD) && !pd_wake_irq_i && !wake_rst_i)
      |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/pwr_bod_gate.sv
module pwr_bod_gate
  import pwr_gate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic [LVL_N-1:0] lvl_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  input  logic             rc_sys_clk_i,
  input  logic             rtc_en_i,
  output logic             cpu_clk_en_o,
  output logic             osc_en_o,
  output logic             rc_osc_en_o,
  output logic             bod_en_o,
  output logic             cmp_en_o,
  output logic             rst_req_o,
  output logic             flash_inh_o,
  output logic             irq_flag_o
);
  logic awake;
  logic irq_set;
  logic irq_flag_q;

  assign awake        = (mode_i == MODE_RUN) || (mode_i == MODE_IDLE);
  assign cpu_clk_en_o = (mode_i == MODE_RUN);
  assign osc_en_o     = awake;
  assign rc_osc_en_o  = awake || (rc_sys_clk_i && rtc_en_i);
  assign bod_en_o     = (mode_i != MODE_TPD);
  assign cmp_en_o     = (mode_i != MODE_TPD);
  assign rst_req_o    = lvl_i[LVL_RST] && bod_en_o;
  assign flash_inh_o  = lvl_i[LVL_FLASH] && awake;

  assign irq_set = lvl_i[LVL_IRQ] && irq_en_i && bod_en_o;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_flag_q <= 1'b0;
    else if (irq_set)   irq_flag_q <= 1'b1;
    else if (irq_clr_i) irq_flag_q <= 1'b0;
  end

  assign irq_flag_o = irq_flag_q;

  // R3
  cpu_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> osc_en_o);

  // R5
  rst_req_needs_bod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> bod_en_o);

  // R7
  flash_inh_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_inh_o |-> osc_en_o);

  // R8
  irq_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_q && !irq_clr_i) |=> irq_flag_q);

  // R8
  irq_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set |=> irq_flag_q);
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TRIP_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_wdata_i,
  input  logic              wake_irq_i,
  input  logic              pd_wake_irq_i,
  input  logic              wake_rst_i,
  input  logic              bo_irq_en_i,
  input  logic              bo_irq_clr_i,
  input  logic              rc_sys_clk_i,
  input  logic              rtc_en_i,
  input  logic              bo_lvl_rst_i,
  input  logic              bo_lvl_irq_i,
  input  logic              bo_lvl_flash_i,
  input  logic [TRIP_W-1:0] bo_rst_trip_i,
  input  logic [TRIP_W-1:0] bo_irq_trip_i,
  output logic [1:0]        mode_o,
  output logic              cpu_clk_en_o,
  output logic              osc_en_o,
  output logic              rc_osc_en_o,
  output logic              bod_en_o,
  output logic              cmp_en_o,
  output logic              bo_rst_req_o,
  output logic              bo_irq_flag_o,
  output logic              bo_flash_inh_o,
  output logic [TRIP_W-1:0] bo_rst_trip_o,
  output logic [TRIP_W-1:0] bo_irq_trip_o
);
  logic [LVL_N-1:0] lvl_raw, lvl_sync;
  mode_e            mode;
  logic             rst_req;
  logic             any_rst;

  assign lvl_raw[LVL_RST]   = bo_lvl_rst_i;
  assign lvl_raw[LVL_IRQ]   = bo_lvl_irq_i;
  assign lvl_raw[LVL_FLASH] = bo_lvl_flash_i;

  pwr_lvl_sync #(.WIDTH(LVL_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lvl_raw),
    .q_o    (lvl_sync)
  );

  // a brownout reset ends Idle and Power-down like any other reset
  assign any_rst = wake_rst_i || rst_req;

  pwr_mode_ctrl i_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (mode_wr_i),
    .wdata_i       (mode_wdata_i),
    .wake_irq_i    (wake_irq_i),
    .pd_wake_irq_i (pd_wake_irq_i),
    .wake_rst_i    (any_rst),
    .mode_o        (mode)
  );

  pwr_bod_gate i_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .lvl_i        (lvl_sync),
    .irq_en_i     (bo_irq_en_i),
    .irq_clr_i    (bo_irq_clr_i),
    .rc_sys_clk_i (rc_sys_clk_i),
    .rtc_en_i     (rtc_en_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .osc_en_o     (osc_en_o),
    .rc_osc_en_o  (rc_osc_en_o),
    .bod_en_o     (bod_en_o),
    .cmp_en_o     (cmp_en_o),
    .rst_req_o    (rst_req),
    .flash_inh_o  (bo_flash_inh_o),
    .irq_flag_o   (bo_irq_flag_o)
  );

  assign mode_o        = mode;
  assign bo_rst_req_o  = rst_req;
  assign bo_rst_trip_o = bo_rst_trip_i;
  assign bo_irq_trip_o = bo_irq_trip_i;

  // R6
  tpd_supervisors_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> (!bod_en_o && !cmp_en_o && !bo_rst_req_o));

  // R5
  bo_rst_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_rst_req_o && (mode_o == 2'b01 || mode_o == 2'b10)) |=> (mode_o == 2'b00));
endmodule

// File: tb/test_pwr_gate_ctrl.sv
module test_pwr_gate_ctrl;
  localparam int TRIP_W = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_wr_i = 0, wake_irq_i = 0, pd_wake_irq_i = 0, wake_rst_i = 0;
  logic [1:0] mode_wdata_i = '0;
  logic bo_irq_en_i = 0, bo_irq_clr_i = 0, rc_sys_clk_i = 0, rtc_en_i = 0;
  logic bo_lvl_rst_i = 0, bo_lvl_irq_i = 0, bo_lvl_flash_i = 0;
  logic [TRIP_W-1:0] bo_rst_trip_i = '0, bo_irq_trip_i = '0;
  logic [1:0] mode_o;
  logic cpu_clk_en_o, osc_en_o, rc_osc_en_o, bod_en_o, cmp_en_o;
  logic bo_rst_req_o, bo_irq_flag_o, bo_flash_inh_o;
  logic [TRIP_W-1:0] bo_rst_trip_o, bo_irq_trip_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4ns clk_i = ~clk_i;

  pwr_gate_ctrl #(.SYNC_STAGES(2), .TRIP_W(TRIP_W)) i_pwr_gate_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic f_awake(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b01);
  endfunction

  function automatic logic f_rc(input logic [1:0] m, input logic sel, input logic rtc);
    return f_awake(m) || (sel && rtc);
  endfunction

  task automatic check_all(input logic [1:0] m);
    chk("R2 mode", 32'(mode_o), 32'(m));
    chk("R3 cpu_clk_en", 32'(cpu_clk_en_o), 32'(m == 2'b00));
    chk("R4 osc_en", 32'(osc_en_o), 32'(f_awake(m)));
    chk("R6 bod_en", 32'(bod_en_o), 32'(m != 2'b11));
    chk("R6 cmp_en", 32'(cmp_en_o), 32'(m != 2'b11));
    chk("R9 rc_osc_en", 32'(rc_osc_en_o), 32'(f_rc(m, rc_sys_clk_i, rtc_en_i)));
    chk("R5 bo_rst_req", 32'(bo_rst_req_o), 32'(bo_lvl_rst_i && m != 2'b11));
    chk("R7 flash_inh", 32'(bo_flash_inh_o), 32'(bo_lvl_flash_i && f_awake(m)));
    chk("R11 rst_trip", 32'(bo_rst_trip_o), 32'(bo_rst_trip_i));
    chk("R11 irq_trip", 32'(bo_irq_trip_o), 32'(bo_irq_trip_i));
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_wr_i = 1; mode_wdata_i = m;
    tick(1);
    mode_wr_i = 0;
  endtask

  task automatic pulse_clr();
    bo_irq_clr_i = 1; tick(1); bo_irq_clr_i = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 cpu_clk_en", 32'(cpu_clk_en_o), 1);
    chk("R1 osc_en", 32'(osc_en_o), 1);
    chk("R1 bod_en", 32'(bod_en_o), 1);
    chk("R1 cmp_en", 32'(cmp_en_o), 1);
    chk("R1 irq_flag", 32'(bo_irq_flag_o), 0);
    rst_ni = 1;
    tick(2);
    check_all(2'b00);

    // R3 Idle: wake_irq_i ends it in one cycle
    write_mode(2'b01);
    check_all(2'b01);
    // R2 write ignored outside run
    write_mode(2'b10);
    chk("R2 write ignored in idle", 32'(mode_o), 1);
    wake_irq_i = 1; tick(1); wake_irq_i = 0;
    chk("R3 idle wake by irq", 32'(mode_o), 0);

    // R4 power-down ignores plain irq, wakes on pd_wake_irq_i
    write_mode(2'b10);
    check_all(2'b10);
    wake_irq_i = 1; tick(3); wake_irq_i = 0;
    chk("R4 pd ignores wake_irq", 32'(mode_o), 2);
    pd_wake_irq_i = 1; tick(1); pd_wake_irq_i = 0;
    chk("R4 pd wake", 32'(mode_o), 0);

    // R4 total power-down wakes on reset event
    write_mode(2'b11);
    check_all(2'b11);
    wake_irq_i = 1; tick(2); wake_irq_i = 0;
    chk("R4 tpd ignores wake_irq", 32'(mode_o), 3);
    wake_rst_i = 1; tick(1); wake_rst_i = 0;
    chk("R4 tpd wake by reset", 32'(mode_o), 0);

    // R10 synchronizer latency
    bo_lvl_flash_i = 1;
    tick(1);
    chk("R10 not after one edge", 32'(bo_flash_inh_o), 0);
    tick(1);
    chk("R10 after two edges", 32'(bo_flash_inh_o), 1);
    bo_lvl_flash_i = 0; tick(3);

    // R8 flag masked in TPD, sets on return, set beats clear
    bo_irq_en_i = 1;
    write_mode(2'b11);
    pulse_clr();
    bo_lvl_irq_i = 1; tick(4);
    chk("R8 flag masked in tpd", 32'(bo_irq_flag_o), 0);
    wake_rst_i = 1; tick(1); wake_rst_i = 0;
    chk("R8 no set on wake edge", 32'(bo_irq_flag_o), 0);
    tick(1);
    chk("R8 set after wake", 32'(bo_irq_flag_o), 1);
    pulse_clr();
    chk("R8 set wins over clear", 32'(bo_irq_flag_o), 1);
    bo_lvl_irq_i = 0; tick(3);
    chk("R8 sticky after level drops", 32'(bo_irq_flag_o), 1);
    pulse_clr();
    chk("R8 cleared", 32'(bo_irq_flag_o), 0);
    bo_irq_en_i = 0; bo_lvl_irq_i = 1; tick(4);
    chk("R8 disabled no set", 32'(bo_irq_flag_o), 0);
    bo_lvl_irq_i = 0; tick(3);

    // R5 brownout reset ends power-down
    write_mode(2'b10);
    bo_lvl_rst_i = 1; tick(2);
    chk("R5 rst req in pd", 32'(bo_rst_req_o), 1);
    tick(1);
    chk("R5 pd ended by brownout reset", 32'(mode_o), 0);
    bo_lvl_rst_i = 0; tick(3);
    write_mode(2'b11);
    bo_lvl_rst_i = 1; tick(4);
    chk("R5 rst req masked in tpd", 32'(bo_rst_req_o), 0);
    chk("R5 tpd stays", 32'(mode_o), 3);
    bo_lvl_rst_i = 0; wake_rst_i = 1; tick(1); wake_rst_i = 0; tick(3);

    // random steady-state sweep
    for (int it = 0; it < 300; it++) begin
      logic [1:0] m, em;
      rc_sys_clk_i   = 1'($urandom);
      rtc_en_i       = 1'($urandom);
      bo_irq_en_i    = 1'($urandom);
      bo_lvl_irq_i   = 1'($urandom);
      bo_lvl_flash_i = 1'($urandom);
      bo_lvl_rst_i   = ($urandom % 4) == 0;
      bo_rst_trip_i  = TRIP_W'($urandom);
      bo_irq_trip_i  = TRIP_W'($urandom);
      tick(4);
      pulse_clr();
      m = 2'($urandom);
      write_mode(m);
      tick(3);
      em = (bo_lvl_rst_i && (m == 2'b01 || m == 2'b10)) ? 2'b00 : m;
      check_all(em);
      chk("R8 random flag", 32'(bo_irq_flag_o), 32'(bo_lvl_irq_i && bo_irq_en_i));
      wake_rst_i = 1; tick(1); wake_rst_i = 0;
      chk("R4 random wake", 32'(mode_o), 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule